// File: doc/BRIEF.md
# Dual-Channel Simultaneous Sample Reader

This block reads one conversion result from each of two channels of a simultaneous-sampling successive-approximation converter: one channel carries a voltage, the other a current. A rising edge on the conversion-start input makes both channels convert at the same instant. After a programmable wait for the conversion to finish, the block lowers chip-select and drives one serial clock to both channels. It shifts the two serial data lines in together, so the two results always belong to the same strobe.

Each raw result has a per-channel offset subtracted and a per-channel gain applied, then it is clamped to the 20-bit signed range. The corrected pair goes into a small first-in first-out queue. A downstream frame builder drains the queue with a valid/ready handshake while it is busy with other work. Two sticky flags, cleared only by reset, record dropped pairs and start edges that arrived too early.

Top module: `dual_adc_reader`

## Requirements
- R1: While reset is low and right after it, chip-select is high, the serial clock is low, `pair_valid` is 0, and both flags are 0.
- R2: Only a 0-to-1 change on `conv_start` starts a read when the reader is idle. Chip-select goes low `conv_delay`+1 clock cycles after the clock edge that samples the change.
- R3: Each read gives exactly `SMP_W` (20) rising serial-clock edges while chip-select is low. The serial clock idles low and each level lasts `SCLK_HALF` clock cycles. Chip-select rises on the same edge as the last falling serial-clock edge.
- R4: Both data lines are sampled on the same rising serial-clock edge, most significant bit first. Each read therefore yields one two's-complement 20-bit word per channel, and both words belong to the same conversion.
- R5: Each channel outputs floor(((raw − offset) × gain) / 2^15). Raw and offset are 20-bit two's complement. Gain is a 16-bit unsigned number in which 32768 means unity.
- R6: A corrected value above 524287 is output as 524287 (0x7FFFF). A value below −524288 is output as −524288 (0x80000).
- R7: Pairs leave in arrival order. `pair_v` and `pair_i` are the voltage and current results. A pair transfers on a clock edge where `pair_valid` and `pair_ready` are both 1. While `pair_ready` is 0, the presented pair and `pair_valid` hold.
- R8: Fullness is judged before any pop in the same cycle. A pair arriving when `FIFO_DEPTH` pairs are stored is discarded, and `overflow_flag` is set and stays set.
- R9: A start edge during a read (waiting or shifting) sets `overrun_flag`, which stays set. It starts no extra read and does not alter the ongoing one.
- R10: Holding `conv_start` high after an edge starts only one read and does not set `overrun_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion strobe, rising edge active |
| conv_delay | input | DLY_W | Conversion wait in clock cycles |
| spi_sclk | output | 1 | Shared serial clock |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_miso_v | input | 1 | Voltage channel serial data |
| spi_miso_i | input | 1 | Current channel serial data |
| offset_v | input | SMP_W | Voltage offset, two's complement |
| offset_i | input | SMP_W | Current offset, two's complement |
| gain_v | input | GAIN_W | Voltage gain, unsigned, unity 2^GAIN_FRAC |
| gain_i | input | GAIN_W | Current gain, unsigned, unity 2^GAIN_FRAC |
| pair_valid | output | 1 | Queue holds a pair |
| pair_ready | input | 1 | Consumer accepts the pair |
| pair_v | output | SMP_W | Corrected voltage sample |
| pair_i | output | SMP_W | Corrected current sample |
| overrun_flag | output | 1 | Sticky: start edge during a read |
| overflow_flag | output | 1 | Sticky: pair dropped on full queue |

## Verification
The bench builds the block with `SCLK_HALF`=2, `FIFO_DEPTH`=4, `DLY_W`=6 and 20-bit samples. The shallow queue fills after four reads while the consumer stalls, so the drop and overflow path is reached in a few hundred cycles. The two-cycle half period keeps each read near 90 cycles, so long stall and drain patterns fit the run. The 6-bit delay lets zero, small and odd conversion waits all be timed exactly.

// File: rtl/dar_pkg.sv
`timescale 1ns/1ps
package dar_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_WAIT  = 2'd1,
    RD_SHIFT = 2'd2
  } rd_state_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/dar_serial_rx.sv
`timescale 1ns/1ps
module dar_serial_rx #(
  parameter int SMP_W     = 20,
  parameter int DLY_W     = 6,
  parameter int SCLK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic [DLY_W-1:0] conv_delay,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  input  logic             miso_v,
  input  logic             miso_i,
  output logic             raw_valid,
  output logic [SMP_W-1:0] raw_v,
  output logic [SMP_W-1:0] raw_i,
  output logic             overrun
);
  import dar_pkg::*;

  localparam int PH_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BC_W = $clog2(SMP_W + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SCLK_HALF - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(SMP_W);

  rd_state_e        state_q, state_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [BC_W-1:0]  bit_q, bit_d;
  logic             sclk_q, sclk_d;
  logic             csn_q, csn_d;
  logic [SMP_W-1:0] shv_q, shv_d, shi_q, shi_d;
  logic             rv_q, rv_d;
  logic             ovr_q, ovr_d;
  logic             start_q;
  logic             start_edge;

  assign start_edge = conv_start & ~start_q;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    sclk_d  = sclk_q;
    csn_d   = csn_q;
    shv_d   = shv_q;
    shi_d   = shi_q;
    rv_d    = 1'b0;
    ovr_d   = ovr_q;
    if (start_edge && (state_q != RD_IDLE)) begin
      ovr_d = 1'b1;
    end
    case (state_q)
      RD_IDLE: begin
        if (start_edge) begin
          state_d = RD_WAIT;
          dly_d   = conv_delay;
        end
      end
      RD_WAIT: begin
        if (dly_q == '0) begin
          state_d = RD_SHIFT;
          csn_d   = 1'b0;
          sclk_d  = 1'b0;
          ph_d    = '0;
          bit_d   = '0;
        end else begin
          dly_d = dly_q - 1'b1;
        end
      end
      RD_SHIFT: begin
        if (ph_q == PH_LAST) begin
          ph_d   = '0;
          sclk_d = ~sclk_q;
          if (!sclk_q) begin
            shv_d = {shv_q[SMP_W-2:0], miso_v};
            shi_d = {shi_q[SMP_W-2:0], miso_i};
            bit_d = bit_q + 1'b1;
          end else if (bit_q == BC_LAST) begin
            csn_d   = 1'b1;
            rv_d    = 1'b1;
            state_d = RD_IDLE;
          end
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      dly_q   <= '0;
      ph_q    <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      shv_q   <= '0;
      shi_q   <= '0;
      rv_q    <= 1'b0;
      ovr_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      sclk_q  <= sclk_d;
      csn_q   <= csn_d;
      shv_q   <= shv_d;
      shi_q   <= shi_d;
      rv_q    <= rv_d;
      ovr_q   <= ovr_d;
      start_q <= conv_start;
    end
  end

  assign spi_sclk  = sclk_q;
  assign spi_cs_n  = csn_q;
  assign raw_valid = rv_q;
  assign raw_v     = shv_q;
  assign raw_i     = shi_q;
  assign overrun   = ovr_q;

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> !csn_q); // R3
  AST_BITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= BC_LAST); // R3
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_q) |-> (rv_q && !sclk_q && $past(sclk_q))); // R3
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RD_IDLE) |-> (csn_q && !sclk_q)); // R1
endmodule

// File: rtl/dar_corrector.sv
`timescale 1ns/1ps
module dar_corrector #(
  parameter int SMP_W     = 20,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SMP_W-1:0]  raw,
  input  logic [SMP_W-1:0]  offset,
  input  logic [GAIN_W-1:0] gain,
  output logic              out_valid,
  output logic [SMP_W-1:0]  out_data
);
  localparam int DW = SMP_W + 1;
  localparam int PW = DW + GAIN_W + 1;
  localparam logic signed [PW-1:0] SAT_HI = PW'((64'sd1 <<< (SMP_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] SAT_LO = PW'(-(64'sd1 <<< (SMP_W - 1)));

  logic signed [DW-1:0] diff;
  logic signed [PW-1:0] diff_x, gain_x, prod, scaled;
  logic [SMP_W-1:0]     sat_d, data_q;
  logic                 valid_q;

  always_comb begin
    diff   = $signed({raw[SMP_W-1], raw}) - $signed({offset[SMP_W-1], offset});
    diff_x = PW'(diff);
    gain_x = PW'($signed({1'b0, gain}));
    prod   = diff_x * gain_x;
    scaled = prod >>> GAIN_FRAC;
    if (scaled > SAT_HI) begin
      sat_d = SAT_HI[SMP_W-1:0];
    end else if (scaled < SAT_LO) begin
      sat_d = SAT_LO[SMP_W-1:0];
    end else begin
      sat_d = scaled[SMP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        data_q <= sat_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  AST_CORR_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R5
  AST_CORR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R5
endmodule

// File: rtl/dar_pair_fifo.sv
`timescale 1ns/1ps
module dar_pair_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          push_ok, pop_ok, full;

  assign full    = (cnt_q == CNT_FULL);
  assign push_ok = push && !full;
  assign pop_ok  = pop && (cnt_q != '0);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (push_ok) begin
      wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
    end
    if (pop_ok) begin
      rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
    end
    if (push_ok && !pop_ok) begin
      cnt_d = cnt_q + 1'b1;
    end else if (!push_ok && pop_ok) begin
      cnt_d = cnt_q - 1'b1;
    end
    if (push && full) begin
      ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_q] <= din;
    end
  end

  assign valid    = (cnt_q != '0);
  assign dout     = mem[rd_q];
  assign overflow = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL); // R8
  AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !pop) |=> (valid && $stable(dout))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R8
endmodule

// File: rtl/dual_adc_reader.sv
`timescale 1ns/1ps
module dual_adc_reader #(
  parameter int SMP_W      = 20,
  parameter int DLY_W      = 6,
  parameter int SCLK_HALF  = 2,
  parameter int GAIN_W     = 16,
  parameter int GAIN_FRAC  = 15,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic [DLY_W-1:0]  conv_delay,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  input  logic              spi_miso_v,
  input  logic              spi_miso_i,
  input  logic [SMP_W-1:0]  offset_v,
  input  logic [SMP_W-1:0]  offset_i,
  input  logic [GAIN_W-1:0] gain_v,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              pair_valid,
  input  logic              pair_ready,
  output logic [SMP_W-1:0]  pair_v,
  output logic [SMP_W-1:0]  pair_i,
  output logic              overrun_flag,
  output logic              overflow_flag
);
  import dar_pkg::*;

  localparam int PAIR_W = NUM_CH * SMP_W;

  logic                raw_valid;
  logic [SMP_W-1:0]    raw_ch  [NUM_CH];
  logic [SMP_W-1:0]    off_ch  [NUM_CH];
  logic [GAIN_W-1:0]   gain_ch [NUM_CH];
  logic [SMP_W-1:0]    corr_ch [NUM_CH];
  logic [NUM_CH-1:0]   corr_valid;
  logic [PAIR_W-1:0]   fifo_din, fifo_dout;

  dar_serial_rx #(
    .SMP_W    (SMP_W),
    .DLY_W    (DLY_W),
    .SCLK_HALF(SCLK_HALF)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .conv_delay(conv_delay),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .miso_v    (spi_miso_v),
    .miso_i    (spi_miso_i),
    .raw_valid (raw_valid),
    .raw_v     (raw_ch[0]),
    .raw_i     (raw_ch[1]),
    .overrun   (overrun_flag)
  );

  assign off_ch[0]  = offset_v;
  assign off_ch[1]  = offset_i;
  assign gain_ch[0] = gain_v;
  assign gain_ch[1] = gain_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dar_corrector #(
      .SMP_W    (SMP_W),
      .GAIN_W   (GAIN_W),
      .GAIN_FRAC(GAIN_FRAC)
    ) u_corr (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (raw_valid),
      .raw      (raw_ch[c]),
      .offset   (off_ch[c]),
      .gain     (gain_ch[c]),
      .out_valid(corr_valid[c]),
      .out_data (corr_ch[c])
    );
    assign fifo_din[c*SMP_W +: SMP_W] = corr_ch[c];
  end

  dar_pair_fifo #(
    .W    (PAIR_W),
    .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (&corr_valid),
    .din     (fifo_din),
    .pop     (pair_ready),
    .valid   (pair_valid),
    .dout    (fifo_dout),
    .overflow(overflow_flag)
  );

  assign pair_v = fifo_dout[0 +: SMP_W];
  assign pair_i = fifo_dout[SMP_W +: SMP_W];

  AST_LANES_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid[0] == corr_valid[1]); // R4
  AST_CS_BEFORE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> corr_valid[0]); // R4
endmodule

// File: tb/dual_adc_reader_bench.sv
`timescale 1ns/1ps
module dual_adc_reader_bench;
  localparam int B_DEPTH = 4;

  typedef struct {
    logic [19:0] v;
    logic [19:0] i;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic [5:0]  conv_delay = '0;
  logic        spi_sclk, spi_cs_n;
  logic        spi_miso_v, spi_miso_i;
  logic [19:0] offset_v = '0, offset_i = '0;
  logic [15:0] gain_v = 16'd32768, gain_i = 16'd32768;
  logic        pair_valid, pair_ready = 1'b0;
  logic [19:0] pair_v, pair_i;
  logic        overrun_flag, overflow_flag;

  int          n_checks = 0;
  int          n_errors = 0;
  logic [19:0] word_v = '0, word_i = '0;
  string       cur_tag = "R4";
  int          idx = 0;
  int          rises = 0;
  int          nreads = 0;
  int          cyc = 0;
  int          pd = 0;
  exp_t        pend;
  exp_t        q[$];
  bit          m_ovf = 1'b0;
  bit          pop_flag = 1'b0;
  logic        prev_csn = 1'b1, prev_sclk = 1'b0;

  always #10 clk = ~clk;

  dual_adc_reader #(
    .SMP_W(20), .DLY_W(6), .SCLK_HALF(2), .GAIN_W(16), .GAIN_FRAC(15), .FIFO_DEPTH(B_DEPTH)
  ) u_dual_adc_reader (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_delay(conv_delay),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_miso_v(spi_miso_v), .spi_miso_i(spi_miso_i),
    .offset_v(offset_v), .offset_i(offset_i), .gain_v(gain_v), .gain_i(gain_i),
    .pair_valid(pair_valid), .pair_ready(pair_ready), .pair_v(pair_v), .pair_i(pair_i),
    .overrun_flag(overrun_flag), .overflow_flag(overflow_flag)
  );

  assign spi_miso_v = (!spi_cs_n && idx < 20) ? word_v[19 - idx] : 1'b0;
  assign spi_miso_i = (!spi_cs_n && idx < 20) ? word_i[19 - idx] : 1'b0;

  function automatic logic [19:0] corr(logic [19:0] raw, logic [19:0] off, logic [15:0] g);
    longint d, p, s;
    d = longint'($signed(raw)) - longint'($signed(off));
    p = d * longint'(g);
    s = p >>> 15;
    if (s > 524287) s = 524287;
    if (s < -524288) s = -524288;
    return s[19:0];
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  always @(posedge clk) begin
    pop_flag <= pair_ready && (q.size() != 0);
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_ovf = 1'b0;
      pd = 0;
      prev_csn = 1'b1;
      prev_sclk = 1'b0;
    end else begin
      cyc++;
      if (cyc > 100000) begin
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
        summary();
      end
      if (prev_csn && !spi_cs_n) begin
        idx = 0;
        rises = 0;
        nreads++;
      end else if (!spi_cs_n && prev_sclk && !spi_sclk) begin
        idx++;
      end
      if (!spi_cs_n && !prev_sclk && spi_sclk) rises++;
      if (pd > 0) begin
        pd--;
        if (pd == 0) begin
          if (q.size() < B_DEPTH) q.push_back(pend);
          else m_ovf = 1'b1;
        end
      end
      if (pop_flag) void'(q.pop_front());
      chk(pair_valid == (q.size() != 0), "R7", "pair_valid", pair_valid, q.size() != 0);
      chk(overflow_flag == m_ovf, "R8", "overflow_flag", overflow_flag, m_ovf);
      if (q.size() != 0) begin
        chk(pair_v == q[0].v, q[0].tag, "pair_v", pair_v, q[0].v);
        chk(pair_i == q[0].i, q[0].tag, "pair_i", pair_i, q[0].i);
      end
      if (!prev_csn && spi_cs_n) begin
        pend.v = corr(word_v, offset_v, gain_v);
        pend.i = corr(word_i, offset_i, gain_i);
        pend.tag = cur_tag;
        pd = 2;
      end
      prev_csn = spi_cs_n;
      prev_sclk = spi_sclk;
    end
  end

  task automatic run_read(logic [19:0] wv, logic [19:0] wi, int dly, string tag, bit hold);
    int k;
    @(negedge clk);
    word_v = wv;
    word_i = wi;
    conv_delay = 6'(dly);
    cur_tag = tag;
    conv_start = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      if (!hold) conv_start = 1'b0;
      k++;
    end while (spi_cs_n && k < 200);
    chk(k == dly + 2, "R2", "cycles to chip-select", k, dly + 2);
    while (!spi_cs_n) @(negedge clk);
    chk(rises == 20, "R3", "sclk rising edges", rises, 20);
    repeat (4) @(negedge clk);
    if (hold) begin
      repeat (60) @(negedge clk);
      conv_start = 1'b0;
    end
  endtask

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1", "sclk in reset", spi_sclk, 0);
    chk(pair_valid == 1'b0, "R1", "valid in reset", pair_valid, 0);
    chk(overrun_flag == 1'b0 && overflow_flag == 1'b0, "R1", "flags in reset",
        {overrun_flag, overflow_flag}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "idle pins after reset",
        {spi_cs_n, spi_sclk}, 2);
    pair_ready = 1'b1;

    // R4: identity correction, coherent pair, both signs
    run_read(20'h12345, 20'hFEDCB, 3, "R4", 1'b0);
    run_read(20'hA5A5A, 20'h05A5A, 0, "R4", 1'b0);
    // R5: offsets and non-unity gains
    offset_v = 20'd100; offset_i = 20'hFFFCE; gain_v = 16'd16384; gain_i = 16'd49152;
    run_read(20'h00400, 20'h80123, 1, "R5", 1'b0);
    offset_v = 20'h00000; offset_i = 20'h00000; gain_v = 16'd1; gain_i = 16'd1;
    run_read(20'hFFFFD, 20'h00005, 7, "R5", 1'b0);
    // R6: saturation high and low
    offset_v = 20'h80000; offset_i = 20'h7FFFF; gain_v = 16'hFFFF; gain_i = 16'hFFFF;
    run_read(20'h7FFFF, 20'h80000, 2, "R6", 1'b0);
    offset_v = 20'h00010; offset_i = 20'hFFFF0; gain_v = 16'd32768; gain_i = 16'd40000;
    // R8: stall consumer, fill queue, drop fifth
    pair_ready = 1'b0;
    for (int n = 0; n < 4; n++) run_read(20'h01000 + 20'(n), 20'hF0000 + 20'(n), 1, "R7", 1'b0);
    chk(overflow_flag == 1'b0, "R8", "no overflow at exactly full", overflow_flag, 0);
    run_read(20'h0BEEF, 20'h0CAFE, 1, "R8", 1'b0);
    repeat (2) @(negedge clk);
    chk(overflow_flag == 1'b1, "R8", "overflow after drop", overflow_flag, 1);
    // R7: drain with toggling ready
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      pair_ready = ~pair_ready;
    end
    pair_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(pair_valid == 1'b0, "R7", "queue drained", pair_valid, 0);
    // R10: level held high starts one read only
    r0 = nreads;
    run_read(20'h33333, 20'hCCCCC, 2, "R10", 1'b1);
    repeat (100) @(negedge clk);
    chk(nreads == r0 + 1, "R10", "reads from held level", nreads - r0, 1);
    chk(overrun_flag == 1'b0, "R10", "no overrun from held level", overrun_flag, 0);
    // R9: extra start edge during shifting
    r0 = nreads;
    @(negedge clk);
    word_v = 20'h44444; word_i = 20'h0ABCD; conv_delay = 6'd2; cur_tag = "R9";
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    while (spi_cs_n) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(overrun_flag == 1'b0, "R9", "overrun before extra edge", overrun_flag, 0);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    @(negedge clk);
    chk(overrun_flag == 1'b1, "R9", "overrun after extra edge", overrun_flag, 1);
    while (!spi_cs_n) @(negedge clk);
    chk(rises == 20, "R9", "ongoing read intact", rises, 20);
    repeat (120) @(negedge clk);
    chk(nreads == r0 + 1, "R9", "no extra read", nreads - r0, 1);
    chk(overrun_flag == 1'b1, "R9", "overrun sticky", overrun_flag, 1);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule